// File: doc/BRIEF.md
# Stack-Based Expression Evaluator

This block is a zero-address datapath. It runs a stream of stack instructions against a small on-chip register stack. Operands are never named. Binary operations take the two topmost entries and leave one result. Unary operations rewrite the top entry in place. Only the load-to-stack and store-from-stack instructions reach outside the block, through a simple data memory request port.

Instructions enter through a valid/ready handshake. An instruction is taken on a rising edge where `instr_valid` and `instr_ready` are both high. `instr_ready` is high only while no memory access is in progress, so any upstream source that respects back-pressure never loses an instruction.

- **Memory requests.** A memory request stays asserted with a stable address, direction and write data until the memory raises `mem_req_ready`.
- **Read responses.** A read returns its word on a later cycle through `mem_rsp_valid`, never in the cycle of the request handshake. Writes have no response.

The stack never spills to memory. When an instruction would grow the stack beyond its capacity, or needs more entries than the stack holds, the block raises an error pulse and leaves the stack unchanged.

Top module: `stack_eval`

## Requirements
- R1: After reset `stack_depth` is 0, `instr_ready` is 1, `mem_req_valid` is 0, and both error outputs are 0.
- R2: Opcode 1 (load) issues a memory read at `instr_addr`. The returned word becomes the new top, and the depth rises by one. `instr_ready` stays low from acceptance until the response has been taken.
- R3: Opcode 2 (store) issues a memory write of the top entry to `instr_addr`, then removes that entry. `instr_ready` stays low until the write handshake.
- R4: Opcode 3 (duplicate) pushes a copy of the top entry, so the depth rises by one and the top value is unchanged.
- R5: Opcodes 4 (add), 5 (subtract), 7 (and), 8 (or) and 9 (xor) each remove the top two entries and push one result, so the depth falls by one. Subtract computes second-from-top minus top.
- R6: Opcode 6 (multiply) behaves like R5 and keeps only the low 16 bits of the product.
- R7: Opcodes 10 (two's-complement negate) and 11 (bitwise invert) replace the top entry and leave the depth unchanged.
- R8: A load or duplicate taken at depth 8 pulses `err_overflow` high for the one cycle after acceptance. The stack is left unchanged and no memory request is made.
- R9: An instruction taken with fewer entries than it consumes pulses `err_underflow` high for the one cycle after acceptance. Store, duplicate and unary operations need 1 entry; binary operations need 2. The stack is left unchanged, no memory request is made, and underflow takes precedence over overflow.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address and direction are held on the next cycle.
- R11: The sequence below leaves a*x*x + b*x + c, modulo 2^16, in memory at y and leaves the stack empty: load a, load x, duplicate, multiply, multiply, load b, load x, multiply, load c, add, add, store y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Instruction can be taken |
| instr_op | input | 4 | Opcode |
| instr_addr | input | ADDR_W | Memory operand address for load and store |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data (top of stack) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Read data |
| stack_top | output | DATA_W | Current top entry (meaningful when depth is above 0) |
| stack_depth | output | $clog2(DEPTH+1) | Number of entries held |
| err_overflow | output | 1 | One-cycle overflow pulse |
| err_underflow | output | 1 | One-cycle underflow pulse |

## Verification
The main program is the quadratic sequence. It is run with small directed coefficients, with zero and all-ones values, and with random coefficients. Small values confirm the operand order through dup and multiply. Wrapping values show whether products are truncated to 16 bits. A directed subtract with distinct operands separates second-from-top minus top from the reverse order. Filling the stack to capacity and operating on an empty stack show that a refused instruction changes neither depth nor top and never reaches memory. A long random instruction stream runs against a software stack model under random memory stall and response latency, which separates correct back-pressure handling from instructions that are dropped or executed twice.

// File: rtl/stack_eval_pkg.sv
package stack_eval_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_DUP  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_MUL  = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_NEG  = 4'd10,
    OP_NOT  = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } st_e;
endpackage

// File: rtl/stack_alu.sv
module stack_alu
  import stack_eval_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_NEG:  res = -rhs;
      OP_NOT:  res = ~rhs;
      default: res = rhs;
    endcase
  end
endmodule

// File: rtl/stack_file.sv
module stack_file #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 pop_cnt,
  input  logic                       push_en,
  input  logic [DATA_W-1:0]          push_val,
  output logic [DATA_W-1:0]          tos,
  output logic [DATA_W-1:0]          nos,
  output logic [$clog2(DEPTH+1)-1:0] depth
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] ent [DEPTH];
  logic [CW-1:0]     base;
  logic [CW-1:0]     tos_pos;
  logic [CW-1:0]     nos_pos;

  assign base    = depth - CW'(pop_cnt);
  assign tos_pos = depth - CW'(1);
  assign nos_pos = depth - CW'(2);
  assign tos     = ent[tos_pos[PW-1:0]];
  assign nos     = ent[nos_pos[PW-1:0]];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rst_n)
          ent[g] <= '0;
        else if (push_en && (base == CW'(g)))
          ent[g] <= push_val;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      depth <= '0;
    else
      depth <= base + CW'(push_en);
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_eval_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  output logic                       instr_ready,
  input  op_e                        op,
  input  logic [ADDR_W-1:0]          instr_addr,
  input  logic [$clog2(DEPTH+1)-1:0] depth,
  input  logic [DATA_W-1:0]          tos,
  input  logic [DATA_W-1:0]          alu_res,
  output logic [1:0]                 pop_cnt,
  output logic                       push_en,
  output logic [DATA_W-1:0]          push_val,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_write,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [DATA_W-1:0]          mem_rsp_data,
  output logic                       err_overflow,
  output logic                       err_underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  st_e               state, state_nxt;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic [1:0]        need;
  logic              grow;
  logic              accept, udf_now, ovf_now, go;

  assign instr_ready = (state == ST_IDLE);
  assign accept      = instr_valid && instr_ready;

  always_comb begin
    need = 2'd0;
    grow = 1'b0;
    case (op)
      OP_PUSH: grow = 1'b1;
      OP_POP:  need = 2'd1;
      OP_DUP:  begin need = 2'd1; grow = 1'b1; end
      OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR: need = 2'd2;
      OP_NEG, OP_NOT: need = 2'd1;
      default: ;
    endcase
  end

  assign udf_now = accept && (depth < CW'(need));
  assign ovf_now = accept && !udf_now && grow && (depth == CW'(DEPTH));
  assign go      = accept && !udf_now && !ovf_now;

  always_comb begin
    state_nxt = state;
    addr_nxt  = addr_q;
    pop_cnt   = 2'd0;
    push_en   = 1'b0;
    push_val  = alu_res;
    case (state)
      ST_IDLE: if (go) begin
        case (op)
          OP_PUSH: begin state_nxt = ST_RD_REQ; addr_nxt = instr_addr; end
          OP_POP:  begin state_nxt = ST_WR_REQ; addr_nxt = instr_addr; end
          OP_DUP:  begin push_en = 1'b1; push_val = tos; end
          OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR: begin
            pop_cnt = 2'd2;
            push_en = 1'b1;
          end
          OP_NEG, OP_NOT: begin
            pop_cnt = 2'd1;
            push_en = 1'b1;
          end
          default: ;
        endcase
      end
      ST_RD_REQ:  if (mem_req_ready) state_nxt = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_valid) begin
        push_en   = 1'b1;
        push_val  = mem_rsp_data;
        state_nxt = ST_IDLE;
      end
      ST_WR_REQ: if (mem_req_ready) begin
        pop_cnt   = 2'd1;
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      addr_q        <= '0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      state         <= state_nxt;
      addr_q        <= addr_nxt;
      err_overflow  <= ovf_now;
      err_underflow <= udf_now;
    end
  end

  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_addr  = addr_q;
endmodule

// File: rtl/stack_eval.sv
module stack_eval
  import stack_eval_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  output logic                       instr_ready,
  input  logic [3:0]                 instr_op,
  input  logic [ADDR_W-1:0]          instr_addr,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_write,
  output logic [ADDR_W-1:0]          mem_req_addr,
  output logic [DATA_W-1:0]          mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [DATA_W-1:0]          mem_rsp_data,
  output logic [DATA_W-1:0]          stack_top,
  output logic [$clog2(DEPTH+1)-1:0] stack_depth,
  output logic                       err_overflow,
  output logic                       err_underflow
);
  op_e               op;
  logic [DATA_W-1:0] tos, nos, alu_res, push_val;
  logic [1:0]        pop_cnt;
  logic              push_en;

  assign op            = op_e'(instr_op);
  assign stack_top     = tos;
  assign mem_req_wdata = tos;

  stack_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (op),
    .lhs (nos),
    .rhs (tos),
    .res (alu_res)
  );

  stack_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_cnt  (pop_cnt),
    .push_en  (push_en),
    .push_val (push_val),
    .tos      (tos),
    .nos      (nos),
    .depth    (stack_depth)
  );

  stack_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_ready   (instr_ready),
    .op            (op),
    .instr_addr    (instr_addr),
    .depth         (stack_depth),
    .tos           (tos),
    .alu_res       (alu_res),
    .pop_cnt       (pop_cnt),
    .push_en       (push_en),
    .push_val      (push_val),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
  );
endmodule

// File: rtl/stack_eval_chk.sv
module stack_eval_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       instr_valid,
  input logic                       instr_ready,
  input logic [3:0]                 instr_op,
  input logic                       mem_req_valid,
  input logic                       mem_req_ready,
  input logic                       mem_req_write,
  input logic [ADDR_W-1:0]          mem_req_addr,
  input logic [$clog2(DEPTH+1)-1:0] stack_depth,
  input logic                       err_overflow,
  input logic                       err_underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic take, is_bin, is_una;
  assign take   = instr_valid && instr_ready;
  assign is_bin = (instr_op >= 4'd4) && (instr_op <= 4'd9);
  assign is_una = (instr_op == 4'd10) || (instr_op == 4'd11);

  // R2
  busy_while_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !instr_ready);

  // R5
  binary_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_bin && (stack_depth >= CW'(2)) |=> stack_depth == $past(stack_depth) - CW'(1));

  // R7
  unary_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_una |=> $stable(stack_depth));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (stack_depth == $past(stack_depth)) && !mem_req_valid);

  // R8
  depth_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= CW'(DEPTH));

  // R9
  udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> (stack_depth == $past(stack_depth)) && !mem_req_valid);

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_overflow && err_underflow));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
endmodule

bind stack_eval stack_eval_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .instr_op      (instr_op),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .stack_depth   (stack_depth),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow)
);

// File: tb/stack_eval_bench.sv
module stack_eval_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DP = 8;
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic          instr_ready;
  logic [3:0]    instr_op = 4'd0;
  logic [AW-1:0] instr_addr = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic          mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [DW-1:0] stack_top;
  logic [CW-1:0] stack_depth;
  logic          err_overflow, err_underflow;

  int tests = 0;
  int fails = 0;
  int req_cnt = 0;
  logic [DW-1:0] bmem [256];
  logic [DW-1:0] mstk [DP];
  int mdepth = 0;

  always #5 clk = ~clk;

  stack_eval #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DP)) u_stack_eval (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .stack_top(stack_top), .stack_depth(stack_depth),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model: random stalls, response latency of 1 to 3 cycles
  logic [DW-1:0] rd_hold = '0;
  int rsp_wait = 0;
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_hold;
        end
      end else if (mem_req_valid && rst_n && ($urandom % 4 != 0)) begin
        mem_req_ready = 1'b1;
        req_cnt++;
        if (mem_req_write) bmem[mem_req_addr] = mem_req_wdata;
        else begin
          rd_hold  = bmem[mem_req_addr];
          rsp_wait = 1 + ($urandom % 3);
        end
      end
    end
  end

  function automatic logic [DW-1:0] alu_model(input logic [3:0] op, input logic [DW-1:0] l,
                                               input logic [DW-1:0] r);
    case (op)
      4'd4:  return l + r;
      4'd5:  return l - r;
      4'd6:  return DW'((32'(l) * 32'(r)) & 32'hFFFF);
      4'd7:  return l & r;
      4'd8:  return l | r;
      4'd9:  return l ^ r;
      4'd10: return DW'(0) - r;
      default: return ~r;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd6: return "R6";
      4'd10, 4'd11: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input logic [3:0] op, input logic [AW-1:0] addr);
    int need = 0;
    bit grow = 0;
    bit e_udf, e_ovf;
    int rc0;
    logic [DW-1:0] st_val = '0;
    logic got_ovf, got_udf;
    case (op)
      4'd1: grow = 1;
      4'd2: need = 1;
      4'd3: begin need = 1; grow = 1; end
      4'd10, 4'd11: need = 1;
      default: need = 2;
    endcase
    e_udf = (mdepth < need);
    e_ovf = !e_udf && grow && (mdepth == DP);
    rc0 = req_cnt;
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op    = op;
    instr_addr  = addr;
    while (!instr_ready) @(negedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    got_ovf = err_overflow;
    got_udf = err_underflow;
    while (!instr_ready) @(negedge clk);
    check("R8 overflow flag", 32'(got_ovf), 32'(e_ovf));
    check("R9 underflow flag", 32'(got_udf), 32'(e_udf));
    if (e_ovf || e_udf) begin
      check(e_ovf ? "R8 no memory access" : "R9 no memory access", 32'(req_cnt), 32'(rc0));
    end else begin
      case (op)
        4'd1: begin mstk[mdepth] = bmem[addr]; mdepth++; end
        4'd2: begin st_val = mstk[mdepth-1]; mdepth--; check("R3 stored word", 32'(bmem[addr]), 32'(st_val)); end
        4'd3: begin mstk[mdepth] = mstk[mdepth-1]; mdepth++; end
        4'd10, 4'd11: mstk[mdepth-1] = alu_model(op, '0, mstk[mdepth-1]);
        default: begin mstk[mdepth-2] = alu_model(op, mstk[mdepth-2], mstk[mdepth-1]); mdepth--; end
      endcase
    end
    check({tag_of(op), " depth"}, 32'(stack_depth), 32'(mdepth));
    if (mdepth > 0) check({tag_of(op), " top"}, 32'(stack_top), 32'(mstk[mdepth-1]));
  endtask

  task automatic poly(input logic [DW-1:0] a, input logic [DW-1:0] x,
                      input logic [DW-1:0] b, input logic [DW-1:0] c);
    logic [DW-1:0] y;
    bmem[0] = a; bmem[1] = x; bmem[2] = b; bmem[3] = c; bmem[4] = '0;
    run(4'd1, 8'd0); run(4'd1, 8'd1); run(4'd3, 8'd0); run(4'd6, 8'd0);
    run(4'd6, 8'd0); run(4'd1, 8'd2); run(4'd1, 8'd1); run(4'd6, 8'd0);
    run(4'd1, 8'd3); run(4'd4, 8'd0); run(4'd4, 8'd0); run(4'd2, 8'd4);
    y = a * x * x + b * x + c;
    check("R11 polynomial result", 32'(bmem[4]), 32'(y));
    check("R11 stack empty", 32'(stack_depth), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) bmem[i] = DW'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 depth", 32'(stack_depth), 32'd0);
    check("R1 ready", 32'(instr_ready), 32'd1);
    check("R1 no request", 32'(mem_req_valid), 32'd0);
    check("R1 errors", 32'({err_overflow, err_underflow}), 32'd0);

    // R9: empty-stack refusals
    run(4'd4, 8'd0); run(4'd2, 8'd9); run(4'd10, 8'd0); run(4'd3, 8'd0);
    bmem[20] = 16'd5;
    run(4'd1, 8'd20); run(4'd5, 8'd0);
    run(4'd2, 8'd21);

    // R5: subtract order, second-from-top minus top
    bmem[10] = 16'd10; bmem[11] = 16'd3;
    run(4'd1, 8'd10); run(4'd1, 8'd11); run(4'd5, 8'd0);
    check("R5 subtract order", 32'(stack_top), 32'd7);
    run(4'd2, 8'd12);

    // R6: product truncation
    bmem[13] = 16'd300;
    run(4'd1, 8'd13); run(4'd3, 8'd0); run(4'd6, 8'd0);
    check("R6 low product bits", 32'(stack_top), 32'd24464);
    run(4'd11, 8'd0); run(4'd10, 8'd0);
    run(4'd2, 8'd14);

    // R8: fill to capacity then refuse load and duplicate
    for (int i = 0; i < DP; i++) run(4'd1, AW'(30 + i));
    run(4'd1, 8'd40); run(4'd3, 8'd0);
    check("R8 full depth kept", 32'(stack_depth), 32'(DP));
    for (int i = 0; i < DP; i++) run(4'd2, AW'(50 + i));

    // R11: directed and random coefficients
    poly(16'd1, 16'd2, 16'd3, 16'd4);
    poly(16'd0, 16'd0, 16'd0, 16'd0);
    poly(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    poly(16'd7, 16'd1000, 16'd13, 16'd2);
    for (int i = 0; i < 20; i++)
      poly(DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom));

    // random stream against the model
    for (int i = 0; i < 400; i++) begin
      int v = $urandom % 16;
      logic [3:0] op = (v == 0) ? 4'd1 : (v < 12) ? 4'(v) : (v < 14) ? 4'd1 : 4'd2;
      run(op, AW'($urandom % 64));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule